// File: doc/BRIEF.md
# Page Table Group Entry Matcher

This block searches one group of eight hashed page-table entries for a translation that matches a lookup request. The request is a virtual page number, a page-size index, a segment size and the hash kind, primary or secondary. From these the block builds a 64-bit compare word. It then reads the first doubleword of each entry through a simple synchronous memory port and compares it with that word. On a hit it also fetches the entry's second doubleword and returns it. The entry index and the entry's secondary-hash flag are returned with it.

The caller loads the group into the memory and sets the request inputs. It pulses `start` for one cycle and waits for the one-cycle `done` pulse. The per-page-size masks arrive as a flat input vector with one 64-bit mask per page-size index. The group address, reference and change updates, locking and replacement are handled elsewhere.

Top module: `pteg_matcher`

## Requirements
- R1: The compare word has the segment size in bits 63:62 and `((vpn >> 11) & ~mask[psize])` placed from bit 7 upward. Bit 2 is the large-page flag, which is set for every `psize` other than 0 (4 KB). Mask index `psize` occupies bits `psize*64 +: 64` of `psize_mask`.
- R2: An entry whose bit 0 (valid) is 0 never hits.
- R3: An entry hits only if its bit 1 (secondary hash) equals `want_sec`. `hit_sec` reports bit 1 of the matched entry.
- R4: An entry hits only if its bit 2 (large page) equals the compare word's bit 2.
- R5: Entry bits 6:3 are ignored. Virtual-page bits cleared by the selected mask are also ignored. Every entry bit from 7 to 63 must equal the compare word.
- R6: Entries are examined in order 0 to 7, and the lowest-numbered matching entry wins.
- R7: On a hit at entry k, `done` pulses k+4 cycles after the clock edge that samples `start`. At the same time `hit` = 1, `hit_idx` = k, and `r_word` holds entry k's second doubleword.
- R8: When nothing matches, `done` pulses 9 cycles after the start edge with `hit` = 0.
- R9: `mem_addr` is `{entry, dw}`, where `dw` = 0 selects the first doubleword and 1 selects the second. `mem_rdata` is valid in the cycle after `mem_rd`. The first read after a start is address 0. A miss reads the first doubleword of all eight entries.
- R10: `start` is ignored while a search is in progress.
- R11: After reset, `done`, `hit` and `mem_rd` are 0.
- R12: `done` lasts exactly one cycle. `hit`, `hit_idx`, `hit_sec` and `r_word` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (one-cycle pulse) |
| vpn | input | 64 | Virtual page number (address >> 12) |
| psize | input | 2 | Page-size index, 0 = 4 KB |
| ssize | input | 2 | Segment size code |
| want_sec | input | 1 | Request entries placed by the secondary hash |
| psize_mask | input | 256 | One compare mask per page-size index |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 4 | Entry index and doubleword select |
| mem_rdata | input | 64 | Read data, one cycle after strobe |
| done | output | 1 | Search finished (pulse) |
| hit | output | 1 | A matching entry was found |
| hit_idx | output | 3 | Index of the matching entry |
| hit_sec | output | 1 | Secondary-hash flag of the matching entry |
| r_word | output | 64 | Second doubleword of the matching entry |

## Verification
The memory returns data one cycle after each strobe, and a compare is resolved on the edge after its data arrives. A hit at entry k therefore produces `done` k+4 edges after the start edge, and a miss produces it 9 edges after. The bench counts falling edges from the start edge until `done` is seen. It checks that count against k+5 or 10, which is the cycle count plus one for the first falling edge after the start edge. All result outputs are sampled on that same falling edge. The held values are checked again one falling edge later, when `done` must already be low.

// File: rtl/pteg_matcher.sv
module pteg_matcher #(
  parameter int NENT   = 8,
  parameter int DW     = 64,
  parameter int NPSIZE = 4,
  localparam int IDXW  = $clog2(NENT),
  localparam int PSW   = $clog2(NPSIZE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DW-1:0]      vpn,
  input  logic [PSW-1:0]     psize,
  input  logic [1:0]         ssize,
  input  logic               want_sec,
  input  logic [NPSIZE*DW-1:0] psize_mask,
  output logic               mem_rd,
  output logic [IDXW:0]      mem_addr,
  input  logic [DW-1:0]      mem_rdata,
  output logic               done,
  output logic               hit,
  output logic [IDXW-1:0]    hit_idx,
  output logic               hit_sec,
  output logic [DW-1:0]      r_word
);

  typedef enum logic [1:0] {IDLE, SCAN, RFETCH, RWAIT} st_t;
  st_t st;

  logic [IDXW:0]   iss_idx;
  logic [IDXW-1:0] cmp_idx;
  logic            cmp_pend;
  logic [DW-1:0]   key_q;
  logic            sec_q;

  wire [DW-1:0] sel_mask = psize_mask[psize*DW +: DW];
  wire [DW-1:0] avpn     = (vpn >> 11) & ~sel_mask;
  wire [DW-1:0] key_n    = {ssize, {(DW-2){1'b0}}} | (avpn << 7)
                         | {{(DW-3){1'b0}}, psize != '0, 2'b00};

  wire match = mem_rdata[0] && (mem_rdata[1] == sec_q) &&
               (mem_rdata[2] == key_q[2]) && (mem_rdata[DW-1:7] == key_q[DW-1:7]);
  wire more  = iss_idx < (IDXW+1)'(NENT);

  assign mem_rd   = (st == SCAN && more) || st == RFETCH;
  assign mem_addr = (st == RFETCH) ? {hit_idx, 1'b1} : {iss_idx[IDXW-1:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      iss_idx  <= '0;
      cmp_idx  <= '0;
      cmp_pend <= 1'b0;
      key_q    <= '0;
      sec_q    <= 1'b0;
      done     <= 1'b0;
      hit      <= 1'b0;
      hit_idx  <= '0;
      hit_sec  <= 1'b0;
      r_word   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st       <= SCAN;
          key_q    <= key_n;
          sec_q    <= want_sec;
          iss_idx  <= '0;
          cmp_pend <= 1'b0;
          hit      <= 1'b0;
        end
        SCAN: begin
          if (more) iss_idx <= iss_idx + 1'b1;
          cmp_pend <= more;
          cmp_idx  <= iss_idx[IDXW-1:0];
          if (cmp_pend && match) begin
            st       <= RFETCH;
            hit_idx  <= cmp_idx;
            hit_sec  <= mem_rdata[1];
            cmp_pend <= 1'b0;
          end else if (cmp_pend && cmp_idx == IDXW'(NENT-1)) begin
            st   <= IDLE;
            done <= 1'b1;
          end
        end
        RFETCH: st <= RWAIT;
        RWAIT: begin
          r_word <= mem_rdata;
          hit    <= 1'b1;
          done   <= 1'b1;
          st     <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hit_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> done);
  assert_first_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st == IDLE) |=> (mem_rd && mem_addr == '0));
  assert_hit_sec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (hit_sec == sec_q));
  assert_rd_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (st != IDLE));

endmodule

// File: tb/test_pteg_matcher.sv
module test_pteg_matcher;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, want_sec = 1'b0;
  logic [63:0] vpn = '0;
  logic [1:0] psize = '0, ssize = '0;
  logic [255:0] psize_mask;
  logic mem_rd, done, hit, hit_sec;
  logic [3:0] mem_addr;
  logic [63:0] mem_rdata = '0, r_word;
  logic [2:0] hit_idx;
  logic [63:0] vmem [8];
  logic [63:0] rmem [8];
  logic [7:0] vseen;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pteg_matcher i_pteg_matcher (.clk(clk), .rst_n(rst_n), .start(start), .vpn(vpn),
    .psize(psize), .ssize(ssize), .want_sec(want_sec), .psize_mask(psize_mask),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
    .hit(hit), .hit_idx(hit_idx), .hit_sec(hit_sec), .r_word(r_word));

  always @(posedge clk) if (mem_rd) begin
    mem_rdata <= mem_addr[0] ? rmem[mem_addr[3:1]] : vmem[mem_addr[3:1]];
    if (!mem_addr[0]) vseen[mem_addr[3:1]] <= 1'b1;
  end

  function automatic logic [63:0] mask_of(input logic [1:0] p);
    case (p)
      2'd0: return 64'h0;
      2'd1: return 64'h1F;
      2'd2: return 64'hFFF;
      default: return 64'h3;
    endcase
  endfunction

  function automatic logic [63:0] key_of(input logic [63:0] v, input logic [1:0] p, input logic [1:0] s);
    logic [63:0] a;
    a = (v >> 11) & ~mask_of(p);
    return {s, 62'b0} | (a << 7) | {61'b0, p != 2'd0, 2'b00};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_group();
    for (int i = 0; i < 8; i++) begin
      vmem[i] = key_of(vpn, psize, ssize) ^ (64'(i + 1) << 40) | {63'b0, 1'b1} | {62'b0, want_sec, 1'b0};
      rmem[i] = 64'hC0DE_0000_0000_0000 | 64'(i * 17 + 3);
    end
  endtask

  function automatic logic [63:0] good(input bit sec);
    return key_of(vpn, psize, ssize) | {62'b0, sec, 1'b1};
  endfunction

  task automatic run(input bit exp_hit, input int k, input string req);
    int cnt = 0;
    logic [63:0] rw;
    vseen = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 1;
    while (!done && cnt < 40) begin @(negedge clk); cnt++; end
    check(done, {req, " watchdog"}, 64'(done), 1);
    check(cnt == (exp_hit ? k + 5 : 10), {req, " latency R7 R8"}, 64'(cnt), 64'(exp_hit ? k + 5 : 10));
    check(hit == exp_hit, {req, " hit"}, 64'(hit), 64'(exp_hit));
    if (exp_hit) begin
      check(hit_idx == 3'(k), {req, " hit_idx R6"}, 64'(hit_idx), 64'(k));
      check(r_word == rmem[k], {req, " r_word R7 R9"}, r_word, rmem[k]);
      check(hit_sec == want_sec, {req, " hit_sec R3"}, 64'(hit_sec), 64'(want_sec));
    end else
      check(vseen == 8'hFF, {req, " all V words read R9"}, 64'(vseen), 64'hFF);
    rw = r_word;
    @(negedge clk);
    check(!done && hit == exp_hit && r_word == rw, {req, " pulse/hold R12"},
          {done, hit, 62'b0}, {1'b0, exp_hit, 62'b0});
  endtask

  task automatic t_reset();
    check(!done && !hit && !mem_rd, "R11 reset", {done, hit, mem_rd}, 0);
  endtask

  task automatic t_basic();
    vpn = 64'h0000_1234_5678_9ABC; psize = 0; ssize = 0; want_sec = 0;
    fill_group(); vmem[0] = good(0);
    run(1, 0, "R1 hit at 0");
    fill_group(); vmem[7] = good(0);
    run(1, 7, "R7 hit at 7");
    fill_group();
    run(0, 0, "R8 miss");
  endtask

  task automatic t_valid();
    vpn = 64'h0000_0ABC_DEF0_1111; psize = 0; ssize = 0; want_sec = 0;
    fill_group(); vmem[2] = good(0) & ~64'h1; vmem[5] = good(0);
    run(1, 5, "R2 invalid skipped");
  endtask

  task automatic t_secondary();
    vpn = 64'h0000_0777_0000_2222; psize = 0; ssize = 0; want_sec = 0;
    fill_group(); vmem[1] = good(1); vmem[4] = good(0);
    run(1, 4, "R3 primary");
    want_sec = 1;
    run(1, 1, "R3 secondary");
  endtask

  task automatic t_large();
    vpn = 64'h0000_0555_1234_0000; psize = 1; ssize = 0; want_sec = 0;
    fill_group(); vmem[0] = good(0) & ~64'h4; vmem[3] = good(0);
    run(1, 3, "R4 large flag");
  endtask

  task automatic t_mask();
    vpn = 64'h0000_0333_4444_5000; psize = 2; ssize = 0; want_sec = 0;
    fill_group(); vmem[1] = good(0) | 64'h78;
    vpn = vpn ^ (64'hABC << 11);
    run(1, 1, "R5 masked and low bits ignored");
  endtask

  task automatic t_priority();
    vpn = 64'h0000_0001_0002_0003; psize = 3; ssize = 0; want_sec = 0;
    fill_group(); vmem[2] = good(0); vmem[6] = good(0);
    run(1, 2, "R6 first of two");
  endtask

  task automatic t_seg();
    vpn = 64'h0000_0999_8888_7000; psize = 0; ssize = 1; want_sec = 0;
    fill_group(); vmem[1] = key_of(vpn, 0, 0) | 64'h1; vmem[5] = good(0);
    run(1, 5, "R1 segment size");
  endtask

  task automatic t_busy();
    int cnt;
    vpn = 64'h0000_0246_8ACE_0000; psize = 0; ssize = 0; want_sec = 0;
    fill_group(); vmem[6] = good(0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); vpn = 64'h0000_0FFF_0000_0000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 3;
    while (!done && cnt < 40) begin @(negedge clk); cnt++; end
    check(done && hit && hit_idx == 3'd6 && cnt == 11, "R10 start ignored while busy",
          {hit_idx, 60'(cnt)}, {3'd6, 60'd11});
    @(negedge clk);
    check(!done && !mem_rd, "R10 no second search", {done, mem_rd}, 0);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) psize_mask[p*64 +: 64] = mask_of(2'(p));
    #1 t_reset();
    #20 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_valid();
    t_secondary();
    t_large();
    t_mask();
    t_priority();
    t_seg();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule